// File: doc/BRIEF.md
# Zero-Crossing Phase Difference Meter

This block measures the phase angle between line voltage and load current from two single-bit square waves, each the output of a zero-crossing detector. The two levels are brought into the local clock domain and combined with an exclusive-OR. The result is high only while the two waveforms disagree. A tick counter driven from a fixed timebase times each such pulse. The tick count is scaled to tenths of a degree for a 50 Hz mains period, where one tick of 0.5 µs is 0.009 degree.

A pulse is classified by how its edges line up with a falling edge of the voltage signal. If the pulse ends at a voltage fall, the voltage leads. If the pulse starts at a voltage fall and does not end at one, the voltage lags. A pulse that matches neither case is discarded. Each accepted pulse produces a one-cycle result strobe with the angle, the lead/lag flag and an overflow flag. These outputs hold their values until the next accepted pulse. A typical system feeds the result to a controller that chooses a compensating capacitance.

Top module: `zc_phase_meter`

## Requirements
- R1: While reset is applied and immediately after it, `res_valid`, `angle_tenths`, `volt_leads` and `overflow` are all 0.
- R2: Both inputs pass through two-flop synchronisers. The result for a pulse appears on the outputs after the fourth rising clock edge that follows the input change ending the pulse. `res_valid` stays low after the first three of those edges.
- R3: A pulse during which the two synchronised inputs differ for H clock cycles yields a tick count of floor(H / TICK_DIV). The count saturates at 2^CNT_W - 1 and never wraps.
- R4: `angle_tenths` equals floor(count * 9 / 100), which is the angle in tenths of a degree for 0.5 µs ticks on a 20 ms period.
- R5: A pulse whose trailing edge comes 0 to WIN clock cycles after a falling edge of the voltage input is reported with `volt_leads` = 1.
- R6: A pulse whose leading edge comes 0 to WIN cycles after a voltage falling edge, and whose trailing edge does not, is reported with `volt_leads` = 0.
- R7: A pulse with neither edge within WIN cycles after a voltage falling edge produces no `res_valid`. `angle_tenths`, `volt_leads` and `overflow` keep their previous values.
- R8: `overflow` is 1 with a result whose count reached saturation, and `angle_tenths` then equals floor((2^CNT_W - 1) * 9 / 100). The next unsaturated result clears it.
- R9: `res_valid` is high for exactly one clock cycle per accepted pulse.
- R10: A pulse edge that comes WIN + 1 cycles after a voltage falling edge is not treated as coincident with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| volt_zc | input | 1 | Voltage zero-crossing square wave, asynchronous |
| curr_zc | input | 1 | Current zero-crossing square wave, asynchronous |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| angle_tenths | output | CNT_W | Phase angle in tenths of a degree |
| volt_leads | output | 1 | 1 when voltage leads current, 0 when it lags |
| overflow | output | 1 | The timed pulse saturated the tick counter |

## Verification
A result is due after the fourth rising edge that follows the input change ending a pulse. Two of those edges are spent in the synchroniser, one in the capture stage and one in the scaling stage. The bench drives every input change at a falling clock edge. It samples `res_valid` at the three following falling edges and expects it low. At the fourth it expects the strobe together with the angle, lead flag and overflow, and at the fifth it expects the strobe gone. Discarded pulses are watched for ten cycles after their end to confirm that no strobe appears and that the held outputs are unchanged.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_LEAD = 2'd1,
    CLS_LAG  = 2'd2
  } pulse_cls_e;

  localparam int unsigned ANG_NUM = 9;
  localparam int unsigned ANG_DEN = 100;
endpackage

// File: rtl/pm_reset_sync.sv
module pm_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= d_async[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign lvl[g]  = sync_q;
    assign rise[g] = sync_q & ~prev_q;
    assign fall[g] = ~sync_q & prev_q;
  end
endmodule

// File: rtl/pm_width_timer.sv
module pm_width_timer #(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             diff_lvl,
  output logic             p_rise,
  output logic             p_fall,
  output logic [CNT_W-1:0] cap_cnt,
  output logic             cap_sat
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic             diff_q;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_adv;
  logic             tick;

  assign p_rise = diff_lvl & ~diff_q;
  assign p_fall = ~diff_lvl & diff_q;
  assign tick   = (pre_q == PRE_LAST);

  always_comb begin
    cnt_adv = cnt_q;
    if (diff_q && tick && (cnt_q != CNT_MAX)) cnt_adv = cnt_q + 1'b1;
  end

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (p_rise) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (diff_q) begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      cnt_d = cnt_adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_q <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
    end else begin
      diff_q <= diff_lvl;
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cap_cnt = cnt_adv;
  assign cap_sat = (cnt_adv == CNT_MAX);
endmodule

// File: rtl/pm_dir_classify.sv
module pm_dir_classify
  import pm_pkg::*;
#(
  parameter int WIN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       v_fall,
  input  logic       p_rise,
  input  logic       p_fall,
  output pulse_cls_e cls
);
  localparam int AGE_W = $clog2(WIN + 2);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WIN + 1);
  localparam logic [AGE_W-1:0] AGE_WIN = AGE_W'(WIN);

  logic [AGE_W-1:0] age_q, age_d;
  logic             lag_q, lag_d;
  logic             recent;

  assign recent = v_fall | (age_q < AGE_WIN);

  always_comb begin
    age_d = age_q;
    if (v_fall)                age_d = '0;
    else if (age_q != AGE_MAX) age_d = age_q + 1'b1;
    lag_d = lag_q;
    if (p_rise) lag_d = recent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= AGE_MAX;
      lag_q <= 1'b0;
    end else begin
      age_q <= age_d;
      lag_q <= lag_d;
    end
  end

  always_comb begin
    cls = CLS_NONE;
    if (p_fall) begin
      if (recent)     cls = CLS_LEAD;
      else if (lag_q) cls = CLS_LAG;
    end
  end
endmodule

// File: rtl/pm_result.sv
module pm_result
  import pm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pulse_cls_e       cls,
  input  logic [CNT_W-1:0] cap_cnt,
  input  logic             cap_sat,
  output logic             res_valid,
  output logic [CNT_W-1:0] angle,
  output logic             lead,
  output logic             ovf
);
  localparam int PROD_W = CNT_W + 4;

  logic             cap_en;
  logic             cap_vld_q;
  logic [CNT_W-1:0] cap_q;
  logic             cap_lead_q, cap_sat_q;
  logic [PROD_W-1:0] prod, quot;
  logic             out_vld_q;
  logic [CNT_W-1:0] ang_q;
  logic             lead_q, ovf_q;

  assign cap_en = (cls != CLS_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld_q  <= 1'b0;
      cap_q      <= '0;
      cap_lead_q <= 1'b0;
      cap_sat_q  <= 1'b0;
    end else begin
      cap_vld_q <= cap_en;
      if (cap_en) begin
        cap_q      <= cap_cnt;
        cap_lead_q <= (cls == CLS_LEAD);
        cap_sat_q  <= cap_sat;
      end
    end
  end

  assign prod = {4'b0000, cap_q} * PROD_W'(ANG_NUM);
  assign quot = prod / PROD_W'(ANG_DEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
      ang_q     <= '0;
      lead_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      out_vld_q <= cap_vld_q;
      if (cap_vld_q) begin
        ang_q  <= quot[CNT_W-1:0];
        lead_q <= cap_lead_q;
        ovf_q  <= cap_sat_q;
      end
    end
  end

  assign res_valid = out_vld_q;
  assign angle     = ang_q;
  assign lead      = lead_q;
  assign ovf       = ovf_q;
endmodule

// File: rtl/zc_phase_meter.sv
module zc_phase_meter
  import pm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 25,
  parameter int WIN      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             volt_zc,
  input  logic             curr_zc,
  output logic             res_valid,
  output logic [CNT_W-1:0] angle_tenths,
  output logic             volt_leads,
  output logic             overflow
);
  localparam int N_IN  = 2;
  localparam int IDX_V = 0;
  localparam int IDX_I = 1;

  logic             rst_n_s;
  logic [N_IN-1:0]  lvl, rise, fall;
  logic             diff_lvl, p_rise, p_fall, cap_sat;
  logic [CNT_W-1:0] cap_cnt;
  pulse_cls_e       cls;

  pm_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pm_edge_sync #(.N(N_IN)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .d_async ({curr_zc, volt_zc}),
    .lvl     (lvl),
    .rise    (rise),
    .fall    (fall)
  );

  assign diff_lvl = lvl[IDX_V] ^ lvl[IDX_I];

  pm_width_timer #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .diff_lvl (diff_lvl),
    .p_rise   (p_rise),
    .p_fall   (p_fall),
    .cap_cnt  (cap_cnt),
    .cap_sat  (cap_sat)
  );

  pm_dir_classify #(.WIN(WIN)) u_dir (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .v_fall (fall[IDX_V]),
    .p_rise (p_rise),
    .p_fall (p_fall),
    .cls    (cls)
  );

  pm_result #(.CNT_W(CNT_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cls       (cls),
    .cap_cnt   (cap_cnt),
    .cap_sat   (cap_sat),
    .res_valid (res_valid),
    .angle     (angle_tenths),
    .lead      (volt_leads),
    .ovf       (overflow)
  );

  logic unused_rise_i;
  assign unused_rise_i = ^{rise, fall[IDX_I]};
endmodule

// File: rtl/zc_phase_meter_chk.sv
module zc_phase_meter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic [CNT_W-1:0] angle_tenths,
  input logic             volt_leads,
  input logic             overflow
);
  localparam longint SAT_ANG = ((64'(1) << CNT_W) - 1) * 9 / 100;

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(angle_tenths) && $stable(volt_leads) && $stable(overflow)));

  p_ovf_angle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (longint'(angle_tenths) == SAT_ANG));

  p_angle_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (longint'(angle_tenths) <= SAT_ANG));
endmodule

bind zc_phase_meter zc_phase_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .res_valid    (res_valid),
  .angle_tenths (angle_tenths),
  .volt_leads   (volt_leads),
  .overflow     (overflow)
);

// File: tb/tb_zc_phase_meter.sv
module tb_zc_phase_meter;
  localparam int CNT_W = 10;
  localparam int DIV   = 5;
  localparam int WIN   = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             volt_zc = 1'b0;
  logic             curr_zc = 1'b0;
  logic             res_valid;
  logic [CNT_W-1:0] angle_tenths;
  logic             volt_leads;
  logic             overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  zc_phase_meter #(.CNT_W(CNT_W), .TICK_DIV(DIV), .WIN(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .volt_zc(volt_zc), .curr_zc(curr_zc),
    .res_valid(res_valid), .angle_tenths(angle_tenths),
    .volt_leads(volt_leads), .overflow(overflow)
  );

  function automatic int exp_angle(input int h);
    int c = h / DIV;
    if (c > (1 << CNT_W) - 1) c = (1 << CNT_W) - 1;
    return (c * 9) / 100;
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic i);
    @(negedge clk);
    volt_zc = v;
    curr_zc = i;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gap_drive(input int n, input logic v, input logic i);
    idle(n - 1);
    drive(v, i);
  endtask

  task automatic expect_result(input string tag, input int ang, input int lead, input int ovf);
    int early = 0;
    repeat (3) begin
      @(negedge clk);
      if (res_valid) early++;
    end
    check_eq({tag, " R2 strobe before 4th edge"}, early, 0);
    @(negedge clk);
    check_eq({tag, " R2 strobe at 4th edge"}, int'(res_valid), 1);
    check_eq({tag, " R4 angle"}, int'(angle_tenths), ang);
    check_eq({tag, " R5/R6 volt_leads"}, int'(volt_leads), lead);
    check_eq({tag, " R8 overflow"}, int'(overflow), ovf);
    @(negedge clk);
    check_eq({tag, " R9 strobe one cycle"}, int'(res_valid), 0);
  endtask

  task automatic expect_none(input string tag, input int ang, input int lead, input int ovf);
    int seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (res_valid) seen++;
    end
    check_eq({tag, " R7 no strobe"}, seen, 0);
    check_eq({tag, " R7 angle held"}, int'(angle_tenths), ang);
    check_eq({tag, " R7 lead held"}, int'(volt_leads), lead);
    check_eq({tag, " R7 overflow held"}, int'(overflow), ovf);
  endtask

  task automatic run_lead(input string tag, input int h, input int ovf);
    drive(1'b1, 1'b1);
    idle(20);
    drive(1'b1, 1'b0);
    gap_drive(h, 1'b0, 1'b0);
    expect_result(tag, exp_angle(h), 1, ovf);
  endtask

  task automatic t_reset();
    idle(3);
    check_eq("R1 valid in reset", int'(res_valid), 0);
    check_eq("R1 angle in reset", int'(angle_tenths), 0);
    rst_n = 1'b1;
    idle(4);
    check_eq("R1 valid after reset", int'(res_valid), 0);
    check_eq("R1 lead after reset", int'(volt_leads), 0);
    check_eq("R1 overflow after reset", int'(overflow), 0);
  endtask

  task automatic t_lead();
    run_lead("R5 R3 lead H=1003", 1003, 0);
  endtask

  task automatic t_lag();
    drive(1'b1, 1'b1);
    idle(20);
    drive(1'b0, 1'b1);
    gap_drive(2500, 1'b0, 1'b0);
    expect_result("R6 lag H=2500", exp_angle(2500), 0, 0);
  endtask

  task automatic t_unclassified();
    drive(1'b1, 1'b0);
    gap_drive(300, 1'b1, 1'b1);
    expect_none("R7 rising-edge pulse", exp_angle(2500), 0, 0);
    drive(1'b0, 1'b0);
    idle(10);
  endtask

  task automatic t_window_in();
    drive(1'b1, 1'b0);
    gap_drive(600, 1'b0, 1'b1);
    gap_drive(2, 1'b0, 1'b0);
    expect_result("R5 fall 2 after v fall", exp_angle(602), 1, 0);
  endtask

  task automatic t_window_out();
    drive(1'b1, 1'b0);
    gap_drive(600, 1'b0, 1'b1);
    gap_drive(3, 1'b0, 1'b0);
    expect_none("R10 fall 3 after v fall", exp_angle(602), 1, 0);
  endtask

  task automatic t_lag_window();
    drive(1'b1, 1'b1);
    idle(20);
    drive(1'b0, 1'b0);
    gap_drive(2, 1'b0, 1'b1);
    gap_drive(700, 1'b0, 1'b0);
    expect_result("R6 rise 2 after v fall", exp_angle(700), 0, 0);
  endtask

  task automatic t_overflow();
    run_lead("R8 R3 saturate H=6000", 6000, 1);
    check_eq("R8 saturated angle", int'(angle_tenths), ((1 << CNT_W) - 1) * 9 / 100);
    run_lead("R8 clear H=1003", 1003, 0);
  endtask

  task automatic t_truncation();
    run_lead("R4 count 11", 55, 0);
    check_eq("R4 floor of 0.99", int'(angle_tenths), 0);
    run_lead("R4 count 12", 60, 0);
    check_eq("R4 floor of 1.08", int'(angle_tenths), 1);
  endtask

  initial begin
    t_reset();
    t_lead();
    t_lag();
    t_unclassified();
    t_window_in();
    t_window_out();
    t_lag_window();
    t_overflow();
    t_truncation();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule